// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Enable Preamble

This block is the transmit half of an asynchronous serial port. A processor writes it through a small bus with two registers: a control register of eight enable bits and a data register of eight bits plus a ninth bit. Each data byte goes out as a frame with a low start bit, the data least significant bit first, and a high stop bit. A format input selects frames with 8 or 9 data bits. Each bit lasts a fixed number of system clocks set by a divider parameter. A bit clock, low in the first half of each bit and high in the second half, is produced next to the data line.

Turning the transmitter on first sends a run of idle ones as a preamble. The run is one frame long, so 10 bits in 8-bit format and 11 bits in 9-bit format. Turning the transmitter off lets the frame in progress finish before the output enables of both pins drop. If the transmitter is turned on again before that frame ends, a new preamble follows the frame. Two flags report the buffer state: "data register empty" and "transmission complete". Each flag drives an interrupt request through its own enable bit. The receive-side bits of the control register are stored and read back but have no effect here.

Top module: `sci_tx_preamble`

## Requirements
- R1: The control register resets to 0x00. A control write stores all eight bits, and `ctl_q` reads them back. Bit positions: 7 data-empty interrupt enable, 6 complete interrupt enable, 5 receive interrupt enable, 4 idle-line interrupt enable, 3 transmitter on (TXON), 2 receiver on, 1 receiver wake-up, 0 send break. `bus_sel` = 0 selects the control register and 1 selects the data register.
- R2: A control write that changes TXON from 0 to 1 starts a preamble of all ones one clock after the write edge. The preamble is 10 bits when `fmt9` = 0 and 11 bits when `fmt9` = 1. A write that leaves TXON at 1 starts no preamble.
- R3: `txd_oe` and `sclk_oe` go to 1 one clock after TXON is set on an idle line. While enabled with nothing to send, `txd` stays 1.
- R4: If TXON is cleared during a frame, the frame completes unchanged. Both output enables drop at the edge that ends the frame. On an idle line they drop one clock after the write.
- R5: If TXON is cleared and set again within one frame, that frame completes and a new preamble starts at once, with no gap in the enables.
- R6: A frame is bit 0 = 0 (start), then data bits LSB first (8, or 9 with the ninth bit when `fmt9` = 1), then a final bit = 1 (stop). Each bit lasts DIV clocks, and a frame starts one clock after its data write on an idle enabled line. Buffered data follows a preamble or frame back to back.
- R7: `tdre` resets to 1. A data write clears it. It is set again at the edge where the data moves into the shifter, and data written while TXON = 0 stays buffered.
- R8: `tc` resets to 1. A data write clears it. It is set at the edge that ends a frame or preamble when nothing follows.
- R9: `irq_tx` = `tdre` AND bit 7, and `irq_tc` = `tc` AND bit 6.
- R10: The output enables change only at a frame or preamble boundary or on an idle line.
- R11: While a bit is on the line, `sclk` is 0 for the first DIV/2 clocks of the bit and 1 for the rest. It is 1 when the line is idle.
- R12: Bits 5, 4, 2, 1 and 0 of the control register do not change `txd`, `sclk` or the output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 = control register, 1 = data register |
| bus_wdata | input | 8 | Write data |
| bus_wbit8 | input | 1 | Ninth data bit, taken with a data write |
| fmt9 | input | 1 | 1 = 9-bit frames, 0 = 8-bit frames |
| ctl_q | output | 8 | Control register read-back |
| txd | output | 1 | Serial data line value |
| txd_oe | output | 1 | Data pin output enable (0 = high impedance) |
| sclk | output | 1 | Bit clock value |
| sclk_oe | output | 1 | Clock pin output enable (0 = high impedance) |
| tdre | output | 1 | Data register empty flag |
| tc | output | 1 | Transmission complete flag |
| irq_tx | output | 1 | Data-empty interrupt request |
| irq_tc | output | 1 | Complete interrupt request |

## Verification
The assertions assume the bus never writes the data register in the same clock that buffered data moves into the shifter. They also assume `fmt9` changes only while the line is idle. The bench meets the first assumption by writing new data only on an idle line, or during a preamble or frame well before its last bit. It changes `fmt9` only between frames, after the complete flag is set. Control writes land at mid-bit points, so the enable changes fall inside frames rather than on their boundaries.

// File: rtl/sci_tx_pkg.sv
package sci_tx_pkg;

    localparam int FRAME_MAX = 11;
    localparam int LEN_W     = 4;

    // Control register, bit 7 first
    typedef struct packed {
        logic tie;   // 7 data-empty interrupt enable
        logic tcie;  // 6 complete interrupt enable
        logic rie;   // 5 receive interrupt enable (stored only)
        logic ilie;  // 4 idle-line interrupt enable (stored only)
        logic txon;  // 3 transmitter on
        logic rxon;  // 2 receiver on (stored only)
        logic rwu;   // 1 wake-up (stored only)
        logic brk;   // 0 send break (stored only)
    } ctl_t;

    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_PRE  = 2'd1,
        LD_DATA = 2'd2
    } load_e;

    function automatic logic [LEN_W-1:0] seq_len(input logic nine);
        return nine ? LEN_W'(11) : LEN_W'(10);
    endfunction

    // Shift vector, bit 0 leaves first
    function automatic logic [FRAME_MAX-1:0] data_frame(
        input logic       nine,
        input logic       b8,
        input logic [7:0] d
    );
        logic [FRAME_MAX-1:0] v;
        v = {1'b1, (nine ? b8 : 1'b1), d, 1'b0};
        return v;
    endfunction

endpackage

// File: rtl/sci_tx_baud.sv
module sci_tx_baud #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick,
    output logic phase_hi
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick     = run && (cnt == CW'(DIV - 1));
    assign phase_hi = (cnt >= CW'(DIV / 2));

    // R11: the last clock of a bit lies in the high half of the bit clock
    a_r11_tick_high_half: assert property (@(posedge clk) disable iff (rst)
        tick |-> phase_hi);

endmodule

// File: rtl/sci_tx_engine.sv
module sci_tx_engine
    import sci_tx_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  load_e                load,
    input  logic [FRAME_MAX-1:0] vec,
    input  logic [LEN_W-1:0]     len,
    output logic                 busy,
    output logic                 fin,
    output logic                 bit_out,
    output logic                 phase_hi
);
    logic [FRAME_MAX-1:0] sh;
    logic [LEN_W-1:0]     idx;
    logic [LEN_W-1:0]     cur_len;
    logic                 tick;
    logic                 take;

    assign take = (load != LD_NONE);

    sci_tx_baud #(.DIV(DIV)) u_baud (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .restart  (take),
        .tick     (tick),
        .phase_hi (phase_hi)
    );

    assign fin     = tick && (idx == cur_len - LEN_W'(1));
    assign bit_out = sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sh      <= '1;
            idx     <= '0;
            cur_len <= '0;
        end else if (take) begin
            busy    <= 1'b1;
            sh      <= vec;
            idx     <= '0;
            cur_len <= len;
        end else if (tick) begin
            if (fin) begin
                busy <= 1'b0;
            end else begin
                sh  <= {1'b1, sh[FRAME_MAX-1:1]};
                idx <= idx + LEN_W'(1);
            end
        end
    end

    // R6: every frame and preamble ends on a high bit
    a_r6_last_bit_high: assert property (@(posedge clk) disable iff (rst)
        fin |-> bit_out);

endmodule

// File: rtl/sci_tx_preamble.sv
module sci_tx_preamble
    import sci_tx_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wbit8,
    input  logic       fmt9,
    output logic [7:0] ctl_q,
    output logic       txd,
    output logic       txd_oe,
    output logic       sclk,
    output logic       sclk_oe,
    output logic       tdre,
    output logic       tc,
    output logic       irq_tx,
    output logic       irq_tc
);
    ctl_t                 ctl;
    logic [7:0]           hold_d;
    logic                 hold_b8;
    logic                 pend_pre;
    logic                 oe_q;
    logic                 busy, fin, bit_out, phase_hi;
    logic                 free;
    logic                 wr_ctl, wr_dat, on_rise;
    load_e                ld;
    logic [FRAME_MAX-1:0] vec;
    ctl_t                 ctl_new;

    assign wr_ctl  = bus_we && !bus_sel;
    assign wr_dat  = bus_we && bus_sel;
    assign ctl_new = ctl_t'(bus_wdata);
    assign on_rise = wr_ctl && ctl_new.txon && !ctl.txon;
    assign free    = !busy || fin;

    always_comb begin
        ld = LD_NONE;
        if (free && ctl.txon) begin
            if (pend_pre)   ld = LD_PRE;
            else if (!tdre) ld = LD_DATA;
        end
    end

    assign vec = (ld == LD_PRE) ? '1 : data_frame(fmt9, hold_b8, hold_d);

    sci_tx_engine #(.DIV(DIV)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .vec      (vec),
        .len      (seq_len(fmt9)),
        .busy     (busy),
        .fin      (fin),
        .bit_out  (bit_out),
        .phase_hi (phase_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            hold_d   <= '0;
            hold_b8  <= 1'b0;
            tdre     <= 1'b1;
            tc       <= 1'b1;
            pend_pre <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            if (wr_ctl) ctl <= ctl_new;
            if (wr_dat) begin
                hold_d  <= bus_wdata;
                hold_b8 <= bus_wbit8;
            end

            if (wr_dat)              tdre <= 1'b0;
            else if (ld == LD_DATA)  tdre <= 1'b1;

            if (wr_dat)                      tc <= 1'b0;
            else if (fin && ld == LD_NONE)   tc <= 1'b1;

            if (on_rise)                     pend_pre <= 1'b1;
            else if (ld == LD_PRE)           pend_pre <= 1'b0;
            else if (free && !ctl.txon)      pend_pre <= 1'b0;

            if (free) oe_q <= ctl.txon;
        end
    end

    assign ctl_q   = ctl;
    assign txd     = busy ? bit_out : 1'b1;
    assign sclk    = busy ? phase_hi : 1'b1;
    assign txd_oe  = oe_q;
    assign sclk_oe = oe_q;
    assign irq_tx  = tdre && ctl.tie;
    assign irq_tc  = tc && ctl.tcie;

    // R2: a rising enable on an idle line starts the engine on the next edge
    a_r2_preamble_starts: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctl.txon) && !busy) |=> busy);

    // R4: a frame ending with the enable cleared releases the pins
    a_r4_release_after_frame: assert property (@(posedge clk) disable iff (rst)
        (fin && !ctl.txon) |=> !txd_oe);

    // R10: pin enables hold while a bit sequence is mid-way
    a_r10_oe_frame_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && !fin) |=> $stable(txd_oe));

    // R7: moving data into the shifter empties the data register
    a_r7_empty_on_load: assert property (@(posedge clk) disable iff (rst)
        (ld == LD_DATA && !wr_dat) |=> tdre);

    // R8: a data write clears the complete flag
    a_r8_write_clears_tc: assert property (@(posedge clk) disable iff (rst)
        wr_dat |=> !tc);

endmodule

// File: tb/sci_tx_preamble_bench.sv
`timescale 1ns/1ps
module sci_tx_preamble_bench;
    localparam int DIV   = 4;
    localparam int LIMIT = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0, bus_sel = 1'b0, bus_wbit8 = 1'b0, fmt9 = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] ctl_q;
    logic       txd, txd_oe, sclk, sclk_oe, tdre, tc, irq_tx, irq_tc;

    int n_run = 0, n_fail = 0, cyc = 0, last_e = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sci_tx_preamble #(.DIV(DIV)) u_sci_tx_preamble (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_wbit8(bus_wbit8), .fmt9(fmt9),
        .ctl_q(ctl_q), .txd(txd), .txd_oe(txd_oe), .sclk(sclk),
        .sclk_oe(sclk_oe), .tdre(tdre), .tc(tc), .irq_tx(irq_tx),
        .irq_tc(irq_tc)
    );

    // {fmt9, ninth bit, data}
    localparam logic [9:0] VEC [0:7] = '{
        {1'b0, 1'b0, 8'h00}, {1'b0, 1'b0, 8'hFF}, {1'b0, 1'b0, 8'hA5},
        {1'b0, 1'b1, 8'h01}, {1'b1, 1'b1, 8'h80}, {1'b1, 1'b0, 8'hFF},
        {1'b1, 1'b1, 8'h3C}, {1'b0, 1'b1, 8'h5A}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic at_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d, input logic b8);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d; bus_wbit8 = b8;
        last_e = cyc + 1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    function automatic int mid(input int e, input int j);
        return e + 1 + j * DIV + DIV / 2;
    endfunction

    // expected frame bit j from the R6 format
    function automatic logic fbit(input logic f, input logic b8, input logic [7:0] d, input int j);
        if (j == 0) return 1'b0;
        if (j <= 8) return d[j-1];
        if (f && j == 9) return b8;
        return 1'b1;
    endfunction

    task automatic check_frame(input string req, input int e, input int off,
                               input logic f, input logic b8, input logic [7:0] d);
        int len = f ? 11 : 10;
        for (int j = 0; j < len; j++) begin
            at_cyc(mid(e, off + j));
            chk(req, 32'(txd), 32'(fbit(f, b8, d, j)));
        end
    endtask

    always @(posedge clk) begin
        if (!finished && cyc > LIMIT) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int e, e2, len;
        at_cyc(5);
        rst = 1'b0;
        @(negedge clk);

        // reset state (R1, R3, R7, R8, R9, R11)
        chk("R1 reset ctl", 32'(ctl_q), 32'h00);
        chk("R3 reset txd_oe", 32'(txd_oe), 0);
        chk("R3 reset sclk_oe", 32'(sclk_oe), 0);
        chk("R7 reset tdre", 32'(tdre), 1);
        chk("R8 reset tc", 32'(tc), 1);
        chk("R9 reset irqs", 32'({irq_tx, irq_tc}), 0);
        chk("R11 idle sclk", 32'(sclk), 1);

        // R12: stored-only bits have no effect
        wr(1'b0, 8'h37, 1'b0);
        chk("R1 ctl readback", 32'(ctl_q), 32'h37);
        at_cyc(last_e + 3 * DIV);
        chk("R12 oe unaffected", 32'({txd_oe, sclk_oe}), 0);
        chk("R12 lines idle", 32'({txd, sclk}), 32'h3);

        // R2/R3: preamble of 10 then frame, fmt9 = 0
        wr(1'b0, 8'h08, 1'b0);
        e = last_e;
        chk("R3 oe not yet", 32'(txd_oe), 0);
        wr(1'b1, 8'hA5, 1'b0);
        at_cyc(e + 1);
        chk("R3 oe on", 32'({txd_oe, sclk_oe}), 32'h3);
        for (int j = 0; j < 10; j++) begin
            at_cyc(mid(e, j));
            chk("R2 preamble bit", 32'(txd), 1);
        end
        check_frame("R2 frame after 10-bit preamble", e, 10, 1'b0, 1'b0, 8'hA5);
        at_cyc(e + 1 + 20 * DIV + 2);
        wr(1'b0, 8'h00, 1'b0);
        at_cyc(last_e + 1);
        chk("R4 idle release", 32'({txd_oe, sclk_oe}), 0);

        // R2: preamble of 11 with fmt9 = 1
        fmt9 = 1'b1;
        wr(1'b0, 8'h08, 1'b0);
        e = last_e;
        wr(1'b1, 8'h3C, 1'b1);
        for (int j = 0; j < 11; j++) begin
            at_cyc(mid(e, j));
            chk("R2 preamble11 bit", 32'(txd), 1);
        end
        check_frame("R6 9-bit frame after 11-bit preamble", e, 11, 1'b1, 1'b1, 8'h3C);
        at_cyc(e + 1 + 22 * DIV + 3);
        chk("R3 idle driven high", 32'({txd_oe, txd}), 32'h3);

        // R6/R7/R8/R11: vector table
        foreach (VEC[i]) begin
            fmt9 = VEC[i][9];
            len = VEC[i][9] ? 11 : 10;
            wr(1'b1, VEC[i][7:0], VEC[i][8]);
            e = last_e;
            chk("R7 write clears tdre", 32'(tdre), 0);
            chk("R8 write clears tc", 32'(tc), 0);
            at_cyc(e + 1);
            chk("R7 tdre set on load", 32'(tdre), 1);
            chk("R11 sclk low first half", 32'(sclk), 0);
            at_cyc(mid(e, 0));
            chk("R11 sclk high second half", 32'(sclk), 1);
            check_frame("R6 table frame", e, 0, VEC[i][9], VEC[i][8], VEC[i][7:0]);
            at_cyc(e + len * DIV);
            chk("R8 tc low on last clock", 32'(tc), 0);
            at_cyc(e + 1 + len * DIV);
            chk("R8 tc set at frame end", 32'(tc), 1);
            at_cyc(e + 3 + len * DIV);
        end

        // R4: disable mid-frame
        fmt9 = 1'b0;
        wr(1'b1, 8'h96, 1'b0);
        e = last_e;
        at_cyc(mid(e, 3));
        wr(1'b0, 8'h00, 1'b0);
        at_cyc(mid(e, 6));
        chk("R4 frame continues", 32'(txd), 32'(fbit(1'b0, 1'b0, 8'h96, 6)));
        chk("R4 oe held", 32'(txd_oe), 1);
        at_cyc(mid(e, 9));
        chk("R4 stop bit sent", 32'(txd), 1);
        at_cyc(e + 10 * DIV);
        chk("R10 oe on last clock", 32'({txd_oe, sclk_oe}), 32'h3);
        at_cyc(e + 1 + 10 * DIV);
        chk("R4 oe off at frame end", 32'({txd_oe, sclk_oe}), 0);

        // R5: off then on within a frame queues a preamble
        wr(1'b0, 8'h08, 1'b0);
        e2 = last_e;
        at_cyc(e2 + 1 + 10 * DIV + 2);
        wr(1'b1, 8'hC3, 1'b0);
        e = last_e;
        at_cyc(mid(e, 2));
        wr(1'b0, 8'h00, 1'b0);
        at_cyc(mid(e, 4));
        wr(1'b0, 8'h08, 1'b0);
        at_cyc(mid(e, 7));
        chk("R5 frame continues", 32'(txd), 32'(fbit(1'b0, 1'b0, 8'hC3, 7)));
        at_cyc(mid(e, 12));
        wr(1'b1, 8'h5A, 1'b0);
        at_cyc(e + 1 + 10 * DIV);
        chk("R5 oe kept at boundary", 32'(txd_oe), 1);
        for (int j = 13; j < 20; j++) begin
            at_cyc(mid(e, j));
            chk("R5 new preamble bit", 32'(txd), 1);
        end
        check_frame("R5 frame after new preamble", e, 20, 1'b0, 1'b0, 8'h5A);
        at_cyc(e + 1 + 30 * DIV + 2);

        // R9: interrupt gating; R2: rewrite of TXON=1 sends no preamble
        chk("R9 irqs disabled", 32'({irq_tx, irq_tc}), 0);
        wr(1'b0, 8'hC8, 1'b0);
        chk("R9 both irqs", 32'({irq_tx, irq_tc}), 32'h3);
        wr(1'b1, 8'h11, 1'b0);
        e = last_e;
        chk("R9 irqs drop on write", 32'({irq_tx, irq_tc}), 0);
        at_cyc(e + 1);
        chk("R9 irq_tx after load", 32'({irq_tx, irq_tc}), 32'h2);
        at_cyc(mid(e, 0));
        chk("R2 no preamble without rise", 32'(txd), 0);
        at_cyc(e + 1 + 10 * DIV);
        chk("R9 irq_tc at end", 32'(irq_tc), 1);
        wr(1'b0, 8'h48, 1'b0);
        chk("R9 tie off", 32'({irq_tx, irq_tc}), 32'h1);

        // R7: data buffered while disabled, sent after preamble
        wr(1'b0, 8'h00, 1'b0);
        wr(1'b1, 8'h77, 1'b0);
        at_cyc(last_e + 4 * DIV);
        chk("R7 data held while off", 32'(tdre), 0);
        chk("R4 pins off", 32'(txd_oe), 0);
        wr(1'b0, 8'h08, 1'b0);
        e = last_e;
        at_cyc(mid(e, 9));
        chk("R2 preamble end", 32'(txd), 1);
        check_frame("R7 buffered frame", e, 10, 1'b0, 1'b0, 8'h77);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule